// File: doc/BRIEF.md
# Packet-Aware Receive Byte Buffer

This block is a 128-entry circular byte store that sits between the receive side of a packet radio link layer and a host. Once the sync detector has found a frame it pulses `sync_det`. The bytes that follow arrive on `wr_valid`/`wr_data`. The first byte after sync is a length value that counts only payload bytes. That length byte is stored, and the payload comes after it. If appending is enabled for the packet, the block then writes two status bytes taken from the `stat_a` and `stat_b` inputs. Several packets can sit in the buffer back to back. The host takes bytes from the head one at a time with `rd_en`. The head byte is always visible on `rd_data`.

The length value is checked against a limit chosen by `stream_mode`. With `stream_mode` low, the whole packet must fit before any read, so the limit is 127. With `stream_mode` high, the host drains the buffer during reception and any 8-bit value up to 255 is allowed. An illegal length byte produces a one-cycle `len_err` pulse. The packet is then dropped with nothing stored. A write that finds no room sets a sticky `overflow` flag, and everything written after that is discarded until `flush`. A read of an empty buffer returns 0x00 and sets a sticky `underflow` flag.

A controller steps through six named states. HUNT waits for sync. LEN takes the length byte. BODY takes payload bytes and counts them down. STA writes status byte A. STB writes status byte B. JAM follows an overflow and holds until flush. The transitions are:
- HUNT to LEN on `sync_det`.
- LEN to BODY on a legal non-zero length.
- LEN to STA on a legal zero length with appending enabled.
- LEN to HUNT on a legal zero length without appending, or on an illegal length.
- BODY to STA or HUNT on the last payload byte, depending on appending.
- STA to STB.
- STB to HUNT.
- LEN, BODY, STA or STB to JAM on a write without room.
- Any state to HUNT on `flush`.

Top module: `pkt_rx_fifo`

## Requirements
- R1: After reset, and after `flush`, `byte_count` is 0, `rd_data` is 0x00, and `overflow`, `underflow`, `pkt_done` and `len_err` are all low.
- R2: Bytes are read out in the order they were stored, across any number of pointer wraps past entry 127. `byte_count` always equals bytes stored minus bytes read. Reading and storing in the same cycle leaves the count unchanged.
- R3: The length byte is stored ahead of its payload and counts payload bytes only. With appending off, `pkt_done` is high for exactly the one cycle after the edge that stores the last payload byte.
- R4: With `append_en` high at sync, `stat_a` and then `stat_b` are stored in the two cycles after the last payload byte, with no `wr_valid` needed. `pkt_done` then pulses after the edge that stores `stat_b`.
- R5: With `stream_mode` low, a length byte above 127 causes a one-cycle `len_err` pulse after its edge. Nothing is stored, `byte_count` is unchanged and the block waits for the next sync. With `stream_mode` high, lengths up to 255 are accepted.
- R6: Packets may follow each other with no gap in storage. For example, four packets of lengths 31, 31, 5 and 57 fill exactly 128 entries.
- R7: A write attempted with `byte_count` at 128 and no read in the same cycle is dropped and sets `overflow`. `overflow` stays high, and all later writes, syncs and length bytes are ignored, until `flush`. Reads keep working.
- R8: `rd_en` with `byte_count` at 0 leaves the count at 0, shows 0x00 on `rd_data` and sets a sticky `underflow` that only `flush` clears.
- R9: `wr_valid` bytes that arrive while waiting for sync are ignored.
- R10: A zero length byte is stored alone. `pkt_done` follows it directly, or follows the two status bytes if appending is on.
- R11: A read in the same cycle as a write frees its entry at once. With 128 bytes held, a write together with a read is accepted without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empties the buffer and clears the sticky flags |
| sync_det | input | 1 | Pulse: a frame was found, so the next byte is its length |
| wr_valid | input | 1 | Received byte valid |
| wr_data | input | 8 | Received byte |
| stream_mode | input | 1 | 0: length limit 127; 1: length limit 255 |
| append_en | input | 1 | Append two status bytes (sampled at sync) |
| stat_a | input | 8 | First status byte |
| stat_b | input | 8 | Second status byte |
| rd_en | input | 1 | Pop the head byte |
| rd_data | output | 8 | Head byte, 0x00 when empty |
| byte_count | output | 8 | Bytes held, 0 to 128 |
| pkt_done | output | 1 | One-cycle pulse when a packet is complete |
| len_err | output | 1 | One-cycle pulse on an illegal length byte |
| overflow | output | 1 | Sticky: a write found no room |
| underflow | output | 1 | Sticky: a read found the buffer empty |

## Verification
The assertions rely on three properties of the inputs. `sync_det` only pulses while the controller is waiting for a frame. `wr_valid` stays low during the two cycles in which status bytes are inserted. `append_en` and `stream_mode` do not change within a packet. The bench drives every packet through a single task that raises sync once, sends the length and payload bytes, and then leaves two idle write cycles when appending. Stimulus therefore stays inside these limits even when reads are interleaved. The bench does not assume a read will find a byte except where it tests underflow on purpose.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

    typedef enum logic [2:0] {
        S_HUNT,
        S_LEN,
        S_BODY,
        S_STA,
        S_STB,
        S_JAM
    } prx_state_e;

endpackage

// File: rtl/pkt_rx_ring.sv
module pkt_rx_ring #(
    parameter int DEPTH = 128,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     push,
    input  logic [DW-1:0]            push_data,
    input  logic                     pop_req,
    output logic [DW-1:0]            rd_data,
    output logic [$clog2(DEPTH):0]   count,
    output logic                     full,
    output logic                     empty,
    output logic                     underflow
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] cnt_q;
    logic          ufl_q;
    logic          pop;

    assign empty     = (cnt_q == '0);
    assign full      = (cnt_q == CW'(DEPTH));
    assign pop       = pop_req && !empty;
    assign count     = cnt_q;
    assign underflow = ufl_q;
    assign rd_data   = empty ? '0 : mem[rptr_q];

    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem[wptr_q] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
            ufl_q  <= 1'b0;
        end else if (flush) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
            ufl_q  <= 1'b0;
        end else begin
            if (push) wptr_q <= wptr_q + 1'b1;
            if (pop)  rptr_q <= rptr_q + 1'b1;
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
            if (pop_req && empty) ufl_q <= 1'b1;
        end
    end

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH)); // R2
    AST_PUSH_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop_req); // R11
    AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty && !push && !flush) |=> (rptr_q == $past(rptr_q) && cnt_q == '0)); // R8
    AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ufl_q && !flush) |=> ufl_q); // R8

endmodule

// File: rtl/pkt_rx_parser.sv
module pkt_rx_parser
    import pkt_rx_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          sync_det,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          stream_mode,
    input  logic          append_en,
    input  logic [DW-1:0] stat_a,
    input  logic [DW-1:0] stat_b,
    input  logic          room,
    output logic          push,
    output logic [DW-1:0] push_data,
    output logic          pkt_done,
    output logic          len_err,
    output logic          overflow
);
    localparam logic [DW:0] LIM_WHOLE  = (DW+1)'(DEPTH - 1);
    localparam logic [DW:0] LIM_STREAM = (DW+1)'((1 << DW) - 1);

    prx_state_e    state_q, state_d;
    logic [DW-1:0] rem_q;
    logic          app_q, done_q, lerr_q, ovf_q;
    logic [DW:0]   lim;
    logic          len_ok, attempt, jam, last_body, len_zero;

    assign lim       = stream_mode ? LIM_STREAM : LIM_WHOLE;
    assign len_ok    = ({1'b0, wr_data} <= lim);
    assign last_body = (rem_q == DW'(1));
    assign len_zero  = (wr_data == '0);

    always_comb begin
        attempt   = 1'b0;
        push_data = wr_data;
        unique case (state_q)
            S_LEN:   attempt = wr_valid && len_ok;
            S_BODY:  attempt = wr_valid;
            S_STA: begin
                attempt   = 1'b1;
                push_data = stat_a;
            end
            S_STB: begin
                attempt   = 1'b1;
                push_data = stat_b;
            end
            default: attempt = 1'b0;
        endcase
    end

    assign push = attempt && room && !flush;
    assign jam  = attempt && !room && !flush;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_HUNT: if (sync_det) state_d = S_LEN;
            S_LEN: begin
                if (wr_valid) begin
                    if (!len_ok)       state_d = S_HUNT;
                    else if (!room)    state_d = S_JAM;
                    else if (len_zero) state_d = app_q ? S_STA : S_HUNT;
                    else               state_d = S_BODY;
                end
            end
            S_BODY: begin
                if (wr_valid) begin
                    if (!room)          state_d = S_JAM;
                    else if (last_body) state_d = app_q ? S_STA : S_HUNT;
                end
            end
            S_STA:   state_d = room ? S_STB  : S_JAM;
            S_STB:   state_d = room ? S_HUNT : S_JAM;
            S_JAM:   state_d = S_JAM;
            default: state_d = S_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state_q <= S_HUNT;
        else if (flush) state_q <= S_HUNT;
        else            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            app_q  <= 1'b0;
            done_q <= 1'b0;
            lerr_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else if (flush) begin
            rem_q  <= '0;
            app_q  <= 1'b0;
            done_q <= 1'b0;
            lerr_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            lerr_q <= 1'b0;
            if (jam) ovf_q <= 1'b1;
            unique case (state_q)
                S_HUNT: if (sync_det) app_q <= append_en;
                S_LEN: begin
                    if (wr_valid && !len_ok) lerr_q <= 1'b1;
                    if (push) begin
                        rem_q <= wr_data;
                        if (len_zero && !app_q) done_q <= 1'b1;
                    end
                end
                S_BODY: begin
                    if (push) begin
                        rem_q <= rem_q - 1'b1;
                        if (last_body && !app_q) done_q <= 1'b1;
                    end
                end
                S_STB:   if (push) done_q <= 1'b1;
                default: ;
            endcase
        end
    end

    assign pkt_done = done_q;
    assign len_err  = lerr_q;
    assign overflow = ovf_q;

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !flush) |=> ovf_q); // R7
    AST_JAM_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_JAM) |-> !push); // R7
    AST_LENERR_REHUNT: assert property (@(posedge clk) disable iff (!rst_n)
        lerr_q |-> (state_q == S_HUNT)); // R5
    AST_BODY_REMAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BODY) |-> (rem_q != '0)); // R3
    AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_q, lerr_q})); // R3
    AST_IDLE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HUNT) |-> !push); // R9

endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo #(
    parameter int DEPTH = 128,
    parameter int DW    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   sync_det,
    input  logic                   wr_valid,
    input  logic [DW-1:0]          wr_data,
    input  logic                   stream_mode,
    input  logic                   append_en,
    input  logic [DW-1:0]          stat_a,
    input  logic [DW-1:0]          stat_b,
    input  logic                   rd_en,
    output logic [DW-1:0]          rd_data,
    output logic [$clog2(DEPTH):0] byte_count,
    output logic                   pkt_done,
    output logic                   len_err,
    output logic                   overflow,
    output logic                   underflow
);
    logic          push, full, empty, room;
    logic [DW-1:0] push_data;

    assign room = !full || rd_en;

    pkt_rx_parser #(.DEPTH(DEPTH), .DW(DW)) u_parser (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .sync_det    (sync_det),
        .wr_valid    (wr_valid),
        .wr_data     (wr_data),
        .stream_mode (stream_mode),
        .append_en   (append_en),
        .stat_a      (stat_a),
        .stat_b      (stat_b),
        .room        (room),
        .push        (push),
        .push_data   (push_data),
        .pkt_done    (pkt_done),
        .len_err     (len_err),
        .overflow    (overflow)
    );

    pkt_rx_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (push),
        .push_data (push_data),
        .pop_req   (rd_en),
        .rd_data   (rd_data),
        .count     (byte_count),
        .full      (full),
        .empty     (empty),
        .underflow (underflow)
    );

    AST_LENERR_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> (byte_count <= $past(byte_count))); // R5

endmodule

// File: tb/test_pkt_rx_fifo.sv
module test_pkt_rx_fifo;
    logic       clk = 1'b0;
    logic       rst_n, flush, sync_det, wr_valid, stream_mode, append_en, rd_en;
    logic [7:0] wr_data, stat_a, stat_b, rd_data, byte_count;
    logic       pkt_done, len_err, overflow, underflow;

    always #10 clk = ~clk;

    pkt_rx_fifo i_pkt_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .sync_det(sync_det),
        .wr_valid(wr_valid), .wr_data(wr_data), .stream_mode(stream_mode),
        .append_en(append_en), .stat_a(stat_a), .stat_b(stat_b), .rd_en(rd_en),
        .rd_data(rd_data), .byte_count(byte_count), .pkt_done(pkt_done),
        .len_err(len_err), .overflow(overflow), .underflow(underflow)
    );

    int         n_chk = 0;
    int         n_err = 0;
    logic [7:0] q[$];
    bit         m_ovf = 1'b0;

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic step(logic [7:0] b, bit wv, int rdm, string tag);
        bit dr;
        dr = (q.size() > 0) && (rdm == 1 || (rdm == 2 && q.size() == 128));
        if (dr) chk(rd_data == q[0], tag, int'(rd_data), int'(q[0]));
        wr_valid = wv;
        wr_data  = b;
        rd_en    = dr;
        if (dr) void'(q.pop_front());
        if (!m_ovf) begin
            if (q.size() == 128) m_ovf = 1'b1;
            else q.push_back(b);
        end
        cyc();
        wr_valid = 1'b0;
        rd_en    = 1'b0;
    endtask

    task automatic send_pkt(int len, bit mode, bit app, int rdm, int seed);
        int lim;
        int c0;
        logic [7:0] sa, sb;
        lim = mode ? 255 : 127;
        sa = 8'(seed ^ 'h5A);
        sb = 8'(~seed);
        stream_mode = mode;
        append_en   = app;
        stat_a      = sa;
        stat_b      = sb;
        sync_det = 1'b1;
        cyc();
        sync_det = 1'b0;
        if (len > lim) begin
            c0 = int'(byte_count);
            wr_valid = 1'b1;
            wr_data  = 8'(len);
            cyc();
            wr_valid = 1'b0;
            chk(len_err == !m_ovf, "R5 len_err pulse", int'(len_err), int'(!m_ovf));
            chk(int'(byte_count) == c0, "R5 count unchanged", int'(byte_count), c0);
            cyc();
            chk(len_err == 1'b0, "R5 len_err one cycle", int'(len_err), 0);
            return;
        end
        step(8'(len), 1'b1, rdm, "R3 read order");
        for (int i = 0; i < len; i++) begin
            step(8'(seed + i * 7), 1'b1, rdm, "R2 read order");
            if (i == 0 && len > 1) chk(pkt_done == 1'b0, "R3 no early done", int'(pkt_done), 0);
        end
        if (app) begin
            chk(pkt_done == 1'b0, "R4 done waits for status", int'(pkt_done), 0);
            step(sa, 1'b0, rdm, "R4 read order");
            step(sb, 1'b0, rdm, "R4 read order");
        end
        chk(pkt_done == !m_ovf, (len == 0) ? "R10 done" : (app ? "R4 done" : "R3 done"),
            int'(pkt_done), int'(!m_ovf));
        chk(int'(byte_count) == q.size(), "R2 count", int'(byte_count), q.size());
        cyc();
        chk(pkt_done == 1'b0, "R3 done one cycle", int'(pkt_done), 0);
    endtask

    task automatic drain(int n, string tag);
        for (int i = 0; i < n; i++) begin
            if (q.size() == 0) break;
            rd_en = 1'b1;
            chk(rd_data == q[0], tag, int'(rd_data), int'(q[0]));
            void'(q.pop_front());
            cyc();
            rd_en = 1'b0;
        end
        chk(int'(byte_count) == q.size(), "R2 count after reads", int'(byte_count), q.size());
    endtask

    task automatic do_flush();
        flush = 1'b1;
        cyc();
        flush = 1'b0;
        q.delete();
        m_ovf = 1'b0;
        chk(byte_count == 8'd0, "R1 flush count", int'(byte_count), 0);
        chk(overflow == 1'b0, "R1 flush overflow", int'(overflow), 0);
        chk(underflow == 1'b0, "R1 flush underflow", int'(underflow), 0);
        chk(rd_data == 8'd0, "R1 flush rd_data", int'(rd_data), 0);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 1'b0; flush = 1'b0; sync_det = 1'b0; wr_valid = 1'b0; wr_data = '0;
        stream_mode = 1'b0; append_en = 1'b0; stat_a = '0; stat_b = '0; rd_en = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        chk(byte_count == 8'd0, "R1 reset count", int'(byte_count), 0);
        chk(rd_data == 8'd0, "R1 reset rd_data", int'(rd_data), 0);
        chk(overflow == 1'b0, "R1 reset overflow", int'(overflow), 0);
        chk(underflow == 1'b0, "R1 reset underflow", int'(underflow), 0);
        chk(pkt_done == 1'b0 && len_err == 1'b0, "R1 reset pulses", int'(pkt_done), 0);

        // R9: stray bytes with no sync
        for (int i = 0; i < 5; i++) step_stray(8'(i + 1));
        chk(byte_count == 8'd0, "R9 stray bytes ignored", int'(byte_count), 0);

        // R2 R3 R4 R10: sweep of short lengths, append alternating, wraps the pointers
        for (int len = 0; len <= 24; len++) begin
            send_pkt(len, 1'b0, len[0], 0, len * 3);
            drain(200, "R2 sweep order");
        end
        for (int len = 0; len <= 12; len++) begin
            send_pkt(len, 1'b1, ~len[0], 1, len + 40);
            drain(200, "R2 interleaved order");
        end

        // R3: largest whole packet fills all entries
        send_pkt(127, 1'b0, 1'b0, 0, 11);
        chk(byte_count == 8'd128, "R3 full with 127", int'(byte_count), 128);
        chk(overflow == 1'b0, "R3 no overflow at 127", int'(overflow), 0);
        drain(200, "R3 drain order");

        // R5: limits by mode
        send_pkt(128, 1'b0, 1'b0, 0, 0);
        send_pkt(255, 1'b0, 1'b1, 0, 0);
        chk(byte_count == 8'd0, "R5 nothing stored", int'(byte_count), 0);
        send_pkt(200, 1'b1, 1'b1, 1, 77);
        chk(overflow == 1'b0, "R5 streamed 200", int'(overflow), 0);
        drain(200, "R5 drain order");

        // R6 then R7
        send_pkt(31, 1'b0, 1'b0, 0, 1);
        send_pkt(31, 1'b0, 1'b0, 0, 2);
        send_pkt(5, 1'b0, 1'b0, 0, 3);
        send_pkt(57, 1'b0, 1'b0, 0, 4);
        chk(byte_count == 8'd128, "R6 back to back fill", int'(byte_count), 128);
        send_pkt(3, 1'b0, 1'b0, 0, 9);
        chk(overflow == 1'b1, "R7 overflow set", int'(overflow), 1);
        chk(byte_count == 8'd128, "R7 byte dropped", int'(byte_count), 128);
        drain(10, "R7 reads still work");
        send_pkt(2, 1'b0, 1'b1, 0, 5);
        send_pkt(200, 1'b0, 1'b0, 0, 0);
        chk(overflow == 1'b1, "R7 overflow sticky", int'(overflow), 1);
        chk(byte_count == 8'd118, "R7 writes ignored", int'(byte_count), 118);
        drain(20, "R7 order after overflow");
        do_flush();

        // R8 underflow
        rd_en = 1'b1;
        chk(rd_data == 8'd0, "R8 empty reads zero", int'(rd_data), 0);
        cyc();
        rd_en = 1'b0;
        chk(underflow == 1'b1, "R8 underflow set", int'(underflow), 1);
        chk(byte_count == 8'd0, "R8 count stays zero", int'(byte_count), 0);
        send_pkt(2, 1'b0, 1'b0, 0, 20);
        drain(200, "R8 order after underflow");
        chk(underflow == 1'b1, "R8 underflow sticky", int'(underflow), 1);
        do_flush();

        // R11: reads at full make room within the same cycle
        send_pkt(130, 1'b1, 1'b0, 2, 33);
        chk(overflow == 1'b0, "R11 no overflow", int'(overflow), 0);
        chk(byte_count == 8'd128, "R11 count at full", int'(byte_count), 128);
        drain(200, "R11 drain order");

        // R9 again: bytes after a finished packet
        for (int i = 0; i < 3; i++) step_stray(8'(i + 9));
        chk(byte_count == 8'd0, "R9 bytes after packet ignored", int'(byte_count), 0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    task automatic step_stray(logic [7:0] b);
        wr_valid = 1'b1;
        wr_data  = b;
        cyc();
        wr_valid = 1'b0;
    endtask

endmodule